// File: doc/BRIEF.md
# DRAM Row Sequencer with Distributed Refresh

This block fronts a behavioural dynamic memory array held inside the design. A client issues single-column reads and writes, each naming a row and a column. Every access passes through four one-cycle phases: bit-line precharge, word-line activation of the addressed row, sensing, and restore. Sensing copies the whole row into a row buffer and leaves the cells empty, so the restore phase always writes the buffer back. For a write, the new column value is merged into the buffer before the write-back.

A free-running interval timer raises one refresh request per interval. Each refresh runs the same four phases on the row named by a wrapping refresh pointer. The whole array is therefore swept once every ROWS intervals. The interval is derived from the clock frequency parameter: one row every 15.6 microseconds, which covers 4096 rows within 64 ms. If a refresh request arrives while an access is in flight, the request is held in a single pending bit. It is served as soon as that access ends, and it is served before any new client request.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, req_ready is high, rd_valid is low, and the refresh pointer is at row 0.
- R2: With no client traffic, a refresh starts every floor(CLK_HZ × 15.6 µs) cycles. Each refresh holds req_ready low for exactly 5 consecutive cycles.
- R3: An accepted read raises rd_valid for exactly one cycle, three clock edges after the edge that accepted it.
- R4: A read returns the value most recently written to the same row and column. A write changes only the addressed column of its row.
- R5: Reading destroys the sensed row internally, yet a location read again returns the same value, because every access restores its row.
- R6: Each refresh senses and restores the row under the refresh pointer. The pointer then steps by one and returns to 0 after row ROWS-1, so no row waits more than ROWS intervals. Stored data survives any number of refresh sweeps.
- R7: A request is taken only on an edge where req_valid and req_ready are both high. Successive acceptances are at least 5 cycles apart, and a request held while req_ready is low is not taken twice.
- R8: A refresh request that arrives during an access waits until that access ends, and then runs before any new request. Under continuous traffic, acceptances are 5 cycles apart, or 10 cycles apart when a refresh was inserted. A second refresh request never arrives while one is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_row | input | $clog2(ROWS) | Row address |
| req_col | input | $clog2(COLS) | Column address within the row |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Sequencer idle with no refresh waiting; a request is taken on this edge |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DW | Read data, meaningful while rd_valid is high |

## Verification
A run with no client traffic isolates the refresh timer: it exposes both the spacing between refreshes and the busy window of each refresh. Column-by-column writes followed by full readbacks separate correct column merging from whole-row overwrites. A second readback of the same data distinguishes a restored row from one left empty after sensing. A quiet period spanning more than two full refresh sweeps, followed by a readback, shows whether refresh restores what it senses. Continuous back-to-back reads reveal whether refresh is deferred cleanly: the spacing between acceptances and a fixed read latency show whether a refresh was slipped in between accesses or cut into one.

// File: rtl/dram_rc_pkg.sv
package dram_rc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRECH,
    PH_ACT,
    PH_SENSE,
    PH_RESTORE
  } phase_t;

  // Cycles per refresh slot: clk_hz * 15.6 us, rounded down.
  function automatic int unsigned refresh_interval(input int unsigned clk_hz);
    longint unsigned prod;
    prod = longint'(clk_hz) * 64'd156;
    return 32'(prod / 64'd10_000_000);
  endfunction

  // Refresh pointer successor with wrap.
  function automatic int unsigned next_row(input int unsigned row, input int unsigned rows);
    return (row == rows - 1) ? 32'd0 : row + 32'd1;
  endfunction

endpackage

// File: rtl/dram_rc_timer.sv
module dram_rc_timer #(
  parameter int unsigned INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [TW-1:0] cnt;

  assign tick = (cnt == TW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/dram_rc_rowctr.sv
module dram_rc_rowctr #(
  parameter int unsigned ROWS = 4096,
  localparam int RW = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          advance,
  output logic [RW-1:0] row
);
  import dram_rc_pkg::*;

  logic [RW-1:0] row_q;
  logic          at_last;

  assign row     = row_q;
  assign at_last = (row_q == RW'(ROWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       row_q <= '0;
    else if (advance) row_q <= RW'(next_row(32'(row_q), ROWS));
  end

  // Watch: refresh slots seen since the pointer last wrapped.
  logic [RW:0] slots_since_wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  slots_since_wrap <= '0;
    else if (advance && at_last) slots_since_wrap <= tick ? (RW+1)'(1) : '0;
    else if (tick)               slots_since_wrap <= slots_since_wrap + 1'b1;
  end

  // R6
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && at_last) |=> (row_q == '0));

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !at_last) |=> (row_q == $past(row_q) + 1'b1));

  // R6
  sweep_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slots_since_wrap <= (RW+1)'(ROWS));

endmodule

// File: rtl/dram_rc_array.sv
module dram_rc_array #(
  parameter int unsigned ROWS = 4096,
  parameter int unsigned COLS = 4,
  parameter int unsigned DW   = 8,
  localparam int RW    = $clog2(ROWS),
  localparam int CW    = $clog2(COLS),
  localparam int ROW_W = COLS * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prech,
  input  logic          act,
  input  logic          sense,
  input  logic          restore,
  input  logic [RW-1:0] row,
  input  logic [CW-1:0] col,
  input  logic          write,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data
);
  logic [ROW_W-1:0] cells [ROWS];
  logic [ROW_W-1:0] row_buf;
  logic [ROW_W-1:0] merged;

  always_comb begin
    merged = row_buf;
    if (write) merged[col*DW +: DW] = wdata;
  end

  assign rd_data = row_buf[col*DW +: DW];

  // Sense drains the cells into the buffer; restore writes them back.
  always_ff @(posedge clk) begin
    if (sense)        cells[row] <= '0;
    else if (restore) cells[row] <= merged;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     row_buf <= '0;
    else if (sense) row_buf <= cells[row];
  end

  // R5
  restore_follows_sense_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sense |=> restore);

  // R3
  act_after_prech_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> $past(prech));

  // R3
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prech, act, sense, restore}));

endmodule

// File: rtl/dram_rc_seq.sv
module dram_rc_seq #(
  parameter int unsigned ROWS = 4096,
  parameter int unsigned COLS = 4,
  parameter int unsigned DW   = 8,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  input  logic [DW-1:0] req_wdata,
  input  logic [RW-1:0] ref_row,
  output logic          req_ready,
  output logic          rd_valid,
  output logic          ref_done,
  output logic          prech,
  output logic          act,
  output logic          sense,
  output logic          restore,
  output logic [RW-1:0] op_row,
  output logic [CW-1:0] op_col,
  output logic          op_write,
  output logic [DW-1:0] op_wdata
);
  import dram_rc_pkg::*;

  phase_t phase, phase_nx;
  logic   pending;
  logic   op_is_ref;
  logic   start_ref;
  logic   accept;

  assign req_ready = (phase == PH_IDLE) && !pending;
  assign start_ref = (phase == PH_IDLE) && pending;
  assign accept    = req_valid && req_ready;

  assign prech    = (phase == PH_PRECH);
  assign act      = (phase == PH_ACT);
  assign sense    = (phase == PH_SENSE);
  assign restore  = (phase == PH_RESTORE);
  assign ref_done = restore && op_is_ref;
  assign rd_valid = restore && !op_is_ref && !op_write;

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE:    if (start_ref || accept) phase_nx = PH_PRECH;
      PH_PRECH:   phase_nx = PH_ACT;
      PH_ACT:     phase_nx = PH_SENSE;
      PH_SENSE:   phase_nx = PH_RESTORE;
      PH_RESTORE: phase_nx = PH_IDLE;
      default:    phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else begin
      if (start_ref) pending <= 1'b0;
      if (tick)      pending <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_row    <= '0;
      op_col    <= '0;
      op_write  <= 1'b0;
      op_wdata  <= '0;
      op_is_ref <= 1'b0;
    end else if (start_ref) begin
      op_row    <= ref_row;
      op_col    <= '0;
      op_write  <= 1'b0;
      op_is_ref <= 1'b1;
    end else if (accept) begin
      op_row    <= req_row;
      op_col    <= req_col;
      op_write  <= req_write;
      op_wdata  <= req_wdata;
      op_is_ref <= 1'b0;
    end
  end

  // R8
  no_missed_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> !pending);

  // R8
  refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_IDLE) && pending) |=> (prech && op_is_ref));

  // R7
  start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prech) |-> ($past(req_valid && req_ready) || $past(pending)));

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int unsigned ROWS   = 4096,
  parameter int unsigned COLS   = 4,
  parameter int unsigned DW     = 8,
  parameter int unsigned CLK_HZ = 100_000_000,
  localparam int RW = $clog2(ROWS),
  localparam int CW = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [RW-1:0] req_row,
  input  logic [CW-1:0] req_col,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned INTERVAL = dram_rc_pkg::refresh_interval(CLK_HZ);

  logic          tick;
  logic          ref_done;
  logic [RW-1:0] ref_row;
  logic          prech, act, sense, restore;
  logic [RW-1:0] op_row;
  logic [CW-1:0] op_col;
  logic          op_write;
  logic [DW-1:0] op_wdata;

  dram_rc_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (tick)
  );

  dram_rc_rowctr #(.ROWS(ROWS)) u_rowctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .advance(ref_done),
    .row    (ref_row)
  );

  dram_rc_seq #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_row  (req_row),
    .req_col  (req_col),
    .req_wdata(req_wdata),
    .ref_row  (ref_row),
    .req_ready(req_ready),
    .rd_valid (rd_valid),
    .ref_done (ref_done),
    .prech    (prech),
    .act      (act),
    .sense    (sense),
    .restore  (restore),
    .op_row   (op_row),
    .op_col   (op_col),
    .op_write (op_write),
    .op_wdata (op_wdata)
  );

  dram_rc_array #(.ROWS(ROWS), .COLS(COLS), .DW(DW)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .prech  (prech),
    .act    (act),
    .sense  (sense),
    .restore(restore),
    .row    (op_row),
    .col    (op_col),
    .write  (op_write),
    .wdata  (op_wdata),
    .rd_data(rd_data)
  );

  // R1
  reset_ptr_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (ref_row == '0 && req_ready && !rd_valid));

endmodule

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;
  localparam int NR  = 16;
  localparam int NC  = 4;
  localparam int W   = 8;
  localparam int HZ  = 2_000_000;
  localparam int SLOT = 15600 / (1_000_000_000 / HZ);  // 31 cycles

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_write = 1'b0;
  logic [3:0]   req_row = '0;
  logic [1:0]   req_col = '0;
  logic [W-1:0] req_wdata = '0;
  logic         req_ready;
  logic         rd_valid;
  logic [W-1:0] rd_data;

  dram_refresh_ctrl #(.ROWS(NR), .COLS(NC), .DW(W), .CLK_HZ(HZ)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_row(req_row), .req_col(req_col), .req_wdata(req_wdata),
    .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act_v, exp_v);
    end
  endtask

  typedef struct { int data; int due; string req; } exp_t;
  exp_t       exp_q[$];
  int         acc_q[$];
  logic [W-1:0] model [NR][NC];

  // Driver: pushes expectations as each request is taken.
  task automatic issue(input bit wr, input int r, input int c, input logic [W-1:0] d,
                       input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_row   = 4'(r);
    req_col   = 2'(c);
    req_wdata = d;
    while (!req_ready) @(negedge clk);
    acc_q.push_back(cyc + 1);
    if (wr) model[r][c] = d;
    else begin
      e.data = int'(model[r][c]);
      e.due  = cyc + 1 + 3;
      e.req  = tag;
      exp_q.push_back(e);
    end
    @(posedge clk);
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++) issue(1'b0, r, c, '0, tag);
  endtask

  // Monitor: pops and compares as read data appears.
  bit prev_rv = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) begin
        exp_t e;
        if (prev_rv) chk(1'b0, "R3", "rd_valid longer than one cycle", 2, 1);
        if (exp_q.size() == 0) chk(1'b0, "R7", "read data with no read taken", 1, 0);
        else begin
          e = exp_q.pop_front();
          chk(int'(rd_data) == e.data, e.req, "read data", int'(rd_data), e.data);
          chk(cyc == e.due, "R3", "read latency cycle", cyc, e.due);
        end
      end
      prev_rv = rd_valid;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "R7", "watchdog expired, run hung", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int falls[$];
    int run_len;
    bit prev_rdy;
    int tens;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", int'(rd_valid), 0);

    // R2: idle refresh cadence and busy window
    prev_rdy = 1'b1;
    run_len  = 0;
    repeat (SLOT * 4 + 12) begin
      @(negedge clk);
      if (!req_ready) begin
        if (prev_rdy) falls.push_back(cyc);
        run_len++;
      end else if (!prev_rdy) begin
        chk(run_len == 5, "R2", "refresh busy cycles", run_len, 5);
        run_len = 0;
      end
      prev_rdy = req_ready;
    end
    chk(falls.size() >= 3, "R2", "refreshes seen while idle", falls.size(), 4);
    for (int i = 1; i < falls.size(); i++)
      chk(falls[i] - falls[i-1] == SLOT, "R2", "refresh spacing",
          falls[i] - falls[i-1], SLOT);

    // R4: column-wise writes, then readback
    for (int r = 0; r < NR; r++)
      for (int c = 0; c < NC; c++)
        issue(1'b1, r, c, 8'(r*13 + c*29 + 7), "R4");
    read_all("R4");
    // R5: same data again, proving restore after sensing
    read_all("R5");
    // R4: overwrite one column only, neighbours must survive
    for (int r = 0; r < NR; r++) issue(1'b1, r, 2, ~8'(r*13 + 2*29 + 7), "R4");
    read_all("R4");

    // R6: idle across more than two full refresh sweeps
    go_idle(SLOT * (2 * NR + 2));
    read_all("R6");

    // R7 / R8: continuous reads with refresh slipped in between
    go_idle(3);
    acc_q.delete();
    read_all("R8");
    go_idle(10);
    tens = 0;
    for (int i = 1; i < acc_q.size(); i++) begin
      int g;
      g = acc_q[i] - acc_q[i-1];
      chk(g >= 5, "R7", "acceptance spacing minimum", g, 5);
      chk(g == 5 || g == 10, "R8", "acceptance spacing under traffic", g, 5);
      if (g == 10) tens++;
    end
    chk(tens > 0, "R8", "refreshes inserted between reads", tens, 1);
    chk(exp_q.size() == 0, "R3", "reads never answered", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule